// File: doc/BRIEF.md
# Fast Context Shadow Register

This block keeps a single saved copy of three core registers of a small processor: the status flags, the working register and the bank select register. An interrupt entry always copies the live values of all three into the shadow store in one cycle. A subroutine call copies them only when its fast bit is set. The copies stay in place until the next save, and any new save replaces them.

A return instruction whose fast bit is set raises a one-cycle restore strobe toward the core register file. While the strobe is high, the three shadow outputs give the values to load. Restoring does not clear or change the store, so a later fast return restores the same values again. A return without the fast bit leaves the core untouched. Field widths are parameters.

Top module: `fast_shadow`

## Requirements
- R1: After reset, all three shadow outputs are zero and `restore_stb` is low.
- R2: When `irq_enter` is sampled high on a clock edge, the shadow outputs show the live `status_in`, `wreg_in` and `bsr_in` values from that edge, starting in the next cycle.
- R3: When `call_stb` and `call_fast` are both sampled high, the three live values are captured in the same way as in R2. When `call_stb` is high and `call_fast` is low, the contents do not change.
- R4: The store has one level. Every save overwrites all three fields, and the earlier contents can no longer be reached.
- R5: When `ret_stb` and `ret_fast` are both sampled high on an edge, `restore_stb` is high for exactly the following cycle. During that cycle the shadow outputs show the contents as they stand after that edge.
- R6: A return with `ret_fast` low produces no `restore_stb` and leaves the contents unchanged.
- R7: A restore leaves the contents unchanged, so back-to-back fast returns restore identical values.
- R8: If `irq_enter` and a fast call are sampled on the same edge, exactly one save of the live values takes place, and it is counted as an interrupt save.
- R9: Without a save event the contents hold. The fast bits have no effect unless their strobe is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_in | input | STATUS_W | Live status flags |
| wreg_in | input | WREG_W | Live working register |
| bsr_in | input | BSR_W | Live bank select register |
| irq_enter | input | 1 | Interrupt entry strobe |
| call_stb | input | 1 | Subroutine call strobe |
| call_fast | input | 1 | Fast bit of the call |
| ret_stb | input | 1 | Return strobe |
| ret_fast | input | 1 | Fast bit of the return |
| shd_status | output | STATUS_W | Saved status flags |
| shd_wreg | output | WREG_W | Saved working register |
| shd_bsr | output | BSR_W | Saved bank select register |
| restore_stb | output | 1 | One-cycle strobe that loads the saved values into the core |

## Verification
The hardest cases to reach are the ones where several strobes meet on one edge. One is an interrupt entry that coincides with a fast call. Another is a fast return that lands on the same edge as a save, so the restore must carry the freshly captured values. The stimulus walks through all 32 combinations of the five strobe and flag inputs, repeated over many cycles. The live values change on every step by arithmetic progressions, so each capture is distinct and a stale or partial save shows up at once.

// File: rtl/fast_shadow_pkg.sv
package fast_shadow_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_IRQ  = 2'd1,
      SRC_CALL = 2'd2
   } save_src_e;

   // Lower bit position of field idx inside the packed live vector.
   function automatic int field_lo(input int idx, input int w0, input int w1);
      int lo;
      lo = 0;
      if (idx > 0) lo += w0;
      if (idx > 1) lo += w1;
      return lo;
   endfunction

   function automatic int field_width(input int idx, input int w0, input int w1, input int w2);
      return (idx == 0) ? w0 : ((idx == 1) ? w1 : w2);
   endfunction

endpackage

// File: rtl/fast_shadow_ctrl.sv
module fast_shadow_ctrl
   import fast_shadow_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      irq_enter,
   input  logic      call_stb,
   input  logic      call_fast,
   input  logic      ret_stb,
   input  logic      ret_fast,
   output logic      save_en,
   output save_src_e save_src,
   output logic      restore_stb
);

   logic fast_call;
   logic fast_ret;

   assign fast_call = call_stb & call_fast;
   assign fast_ret  = ret_stb & ret_fast;

   always_comb begin
      if (irq_enter)      save_src = SRC_IRQ;
      else if (fast_call) save_src = SRC_CALL;
      else                save_src = SRC_NONE;
   end

   assign save_en = (save_src != SRC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restore_stb <= 1'b0;
      else        restore_stb <= fast_ret;
   end

   assert_irq_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |-> save_src == SRC_IRQ);

   assert_fast_call_saves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (call_stb && call_fast) |-> save_en);

   assert_restore_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_stb && ret_fast) |=> restore_stb);

   assert_no_stray_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ret_stb && ret_fast) |=> !restore_stb);

endmodule

// File: rtl/fast_shadow_field.sv
module fast_shadow_field #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("fast_shadow_field: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/fast_shadow.sv
module fast_shadow
   import fast_shadow_pkg::*;
#(
   parameter int STATUS_W = 5,
   parameter int WREG_W   = 8,
   parameter int BSR_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] status_in,
   input  logic [WREG_W-1:0]   wreg_in,
   input  logic [BSR_W-1:0]    bsr_in,
   input  logic                irq_enter,
   input  logic                call_stb,
   input  logic                call_fast,
   input  logic                ret_stb,
   input  logic                ret_fast,
   output logic [STATUS_W-1:0] shd_status,
   output logic [WREG_W-1:0]   shd_wreg,
   output logic [BSR_W-1:0]    shd_bsr,
   output logic                restore_stb
);

   localparam int NFIELD  = 3;
   localparam int TOTAL_W = STATUS_W + WREG_W + BSR_W;

   generate
      if (STATUS_W < 1 || WREG_W < 1 || BSR_W < 1) begin : g_bad_cfg
         $error("fast_shadow: every field width must be at least 1");
      end
   endgenerate

   logic [TOTAL_W-1:0] live_vec;
   logic [TOTAL_W-1:0] shadow_vec;
   logic               save_en;
   save_src_e          save_src;

   assign live_vec = {bsr_in, wreg_in, status_in};

   fast_shadow_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_enter   (irq_enter),
      .call_stb    (call_stb),
      .call_fast   (call_fast),
      .ret_stb     (ret_stb),
      .ret_fast    (ret_fast),
      .save_en     (save_en),
      .save_src    (save_src),
      .restore_stb (restore_stb)
   );

   for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
      localparam int FW = field_width(gi, STATUS_W, WREG_W, BSR_W);
      localparam int LO = field_lo(gi, STATUS_W, WREG_W);
      fast_shadow_field #(.W(FW)) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (save_en),
         .d     (live_vec[LO +: FW]),
         .q     (shadow_vec[LO +: FW])
      );
   end

   assign shd_status = shadow_vec[STATUS_W-1:0];
   assign shd_wreg   = shadow_vec[STATUS_W +: WREG_W];
   assign shd_bsr    = shadow_vec[STATUS_W+WREG_W +: BSR_W];

   assert_irq_saves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> {shd_bsr, shd_wreg, shd_status} == $past(live_vec));

   assert_restore_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_stb && !save_en) |=> $stable(shadow_vec));

endmodule

// File: tb/fast_shadow_test.sv
`timescale 1ns/1ps
module fast_shadow_test;

   localparam int SW = 5;
   localparam int WW = 8;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] status_in = '0;
   logic [WW-1:0] wreg_in = '0;
   logic [BW-1:0] bsr_in = '0;
   logic          irq_enter = 1'b0, call_stb = 1'b0, call_fast = 1'b0;
   logic          ret_stb = 1'b0, ret_fast = 1'b0;
   logic [SW-1:0] shd_status;
   logic [WW-1:0] shd_wreg;
   logic [BW-1:0] shd_bsr;
   logic          restore_stb;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   fast_shadow #(.STATUS_W(SW), .WREG_W(WW), .BSR_W(BW)) uut (
      .clk(clk), .rst_n(rst_n),
      .status_in(status_in), .wreg_in(wreg_in), .bsr_in(bsr_in),
      .irq_enter(irq_enter), .call_stb(call_stb), .call_fast(call_fast),
      .ret_stb(ret_stb), .ret_fast(ret_fast),
      .shd_status(shd_status), .shd_wreg(shd_wreg), .shd_bsr(shd_bsr),
      .restore_stb(restore_stb)
   );

   logic [SW-1:0] e_st;
   logic [WW-1:0] e_w;
   logic [BW-1:0] e_b;
   logic          e_rs;

   task automatic check_all(input string req);
      checks++;
      if (shd_status !== e_st || shd_wreg !== e_w || shd_bsr !== e_b || restore_stb !== e_rs) begin
         errors++;
         $display("FAIL %s: got st=%h w=%h b=%h rs=%b expected st=%h w=%h b=%h rs=%b",
                  req, shd_status, shd_wreg, shd_bsr, restore_stb, e_st, e_w, e_b, e_rs);
      end
   endtask

   // Drive at negedge, let one posedge pass, sample at the next negedge.
   task automatic step(input logic irq, input logic cs, input logic cf,
                       input logic rs, input logic rf, input int n);
      status_in = SW'(n * 7 + 3);
      wreg_in   = WW'(n * 37 + 11);
      bsr_in    = BW'(n * 5 + 1);
      irq_enter = irq; call_stb = cs; call_fast = cf; ret_stb = rs; ret_fast = rf;
      if (irq || (cs && cf)) begin
         e_st = status_in; e_w = wreg_in; e_b = bsr_in;
      end
      e_rs = rs && rf;
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      e_st = '0; e_w = '0; e_b = '0; e_rs = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // R2: interrupt save
      step(1, 0, 0, 0, 0, 1);  check_all("R2 irq save");
      // R3: non-fast call leaves contents
      step(0, 1, 0, 0, 0, 2);  check_all("R3 plain call");
      step(0, 1, 1, 0, 0, 3);  check_all("R3 fast call");
      // R4: overwrite
      step(1, 0, 0, 0, 0, 4);  check_all("R4 overwrite");
      // R5 / R7: back-to-back fast returns
      step(0, 0, 0, 1, 1, 5);  check_all("R5 restore pulse");
      step(0, 0, 0, 1, 1, 6);  check_all("R7 second restore");
      step(0, 0, 0, 0, 0, 7);  check_all("R5 strobe drops");
      // R6: plain return
      step(0, 0, 0, 1, 0, 8);  check_all("R6 plain return");
      // R8: interrupt with fast call
      step(1, 1, 1, 0, 0, 9);  check_all("R8 simultaneous save");
      // R9: flags without strobes
      step(0, 0, 1, 0, 1, 10); check_all("R9 flags alone");

      // Sweep of all strobe and flag combinations.
      for (int i = 0; i < 2048; i++) begin
         logic [4:0] op;
         op = 5'(i * 13 + i / 32);
         step(op[4], op[3], op[2], op[1], op[0], i + 20);
         if (op[4] && op[3] && op[2])     check_all("R8 sweep");
         else if (op[4])                  check_all("R2 sweep");
         else if (op[3])                  check_all("R3 sweep");
         else if (op[1] && op[0])         check_all("R7 sweep");
         else if (op[1])                  check_all("R6 sweep");
         else                             check_all("R9 sweep");
      end

      // Reset mid-run returns to zero.
      step(1, 0, 0, 0, 0, 99);
      rst_n = 1'b0;
      e_st = '0; e_w = '0; e_b = '0; e_rs = 1'b0;
      irq_enter = 0; ret_stb = 0;
      @(negedge clk);
      check_all("R1 reset again");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule